// File: doc/BRIEF.md
# Multi-Operand Computation Unit Controller

This block is the sequencing wrapper between a register-file scoreboard and a simple function unit. A one-cycle issue pulse starts an operation. The unit then raises a read request for each source operand that must come from the register file. As each matching grant arrives, it latches that operand. Once no read request is left, it offers the gathered operands to the function unit through a valid/ready pair. It then waits for the result strobe, captures the result, and raises one write request per destination. It releases itself once every destination has been granted.

Two build-time options can take source operands out of the read phase. With the zero option, operand A can be forced to zero. With the immediate option, operand B can be taken from an immediate input. The number of sources (1 to 3) and destinations (1 to 2) are parameters. An active-low shadow input holds off write completion. A kill input abandons the operation at once. Busy and done are separate outputs: done always falls one cycle after busy.

Top module: `compunit_ctrl`

## Requirements
- R1: An issue pulse seen while done is low makes busy and done high in the next cycle. Read-request bit i is then high for each source that must be read.
- R2: A read-request bit clears in the cycle after its grant is seen, and the operand is latched from its slice of rd_data_i (source i at bits i*DW upward) at that grant. A grant on a bit whose request is already low changes nothing.
- R3: alu_req_o is high only while busy is high and every read-request bit is low, and it stays high until alu_ack_i is seen. While it is high, alu_op_o carries the latched operands (source i at bits i*DW upward).
- R4: When zero support is built in and zero_a_i is high at issue, operand A is zero and read-request bit 0 is never raised.
- R5: When immediate support is built in and imm_sel_i is high at issue, operand B equals imm_i and read-request bit 1 is never raised.
- R6: After alu_req_o has been accepted, alu_res_valid_i captures alu_res_i and raises every write-request bit in the next cycle. While any write request is high, all read requests are low.
- R7: While shadow_n_i is low, write grants are ignored and the write requests hold.
- R8: In the cycle after the last outstanding write request meets its grant (with shadow_n_i high), write requests and busy are low. data_o then equals the captured result (destination j at bits j*DW upward).
- R9: Done falls exactly one cycle after busy falls.
- R10: A kill seen while busy clears all requests in the next cycle. Busy then stays high for one more cycle before clearing. Kill wins over a final write grant in the same cycle.
- R11: An issue pulse while done is high is ignored.
- R12: While done is low, no read request, write request or function-unit request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One-cycle start pulse |
| zero_a_i | input | 1 | Force operand A to zero (sampled at issue) |
| imm_sel_i | input | 1 | Take operand B from imm_i (sampled at issue) |
| imm_i | input | DW | Immediate value |
| rd_req_o | output | NSRC | Per-source read requests |
| rd_grant_i | input | NSRC | Per-source read grants |
| rd_data_i | input | NSRC*DW | Source operand values |
| alu_req_o | output | 1 | Operands valid to function unit |
| alu_ack_i | input | 1 | Function unit ready |
| alu_op_o | output | NSRC*DW | Latched operands |
| alu_res_valid_i | input | 1 | Result strobe |
| alu_res_i | input | NDST*DW | Result values |
| wr_req_o | output | NDST | Per-destination write requests |
| wr_grant_i | input | NDST | Per-destination write grants |
| shadow_n_i | input | 1 | Low holds off write completion |
| kill_i | input | 1 | Abandon current operation |
| data_o | output | NDST*DW | Captured result |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Busy delayed on its falling edge |

## Verification
Two events can meet in one cycle: a kill and the grant that would retire the final write request. The bench drives both in the same cycle. It then expects the write requests to clear while busy stays high for one more cycle, as the kill path requires, and not to drop at once as a normal completion would. A second overlap comes from granting every needed source in one cycle. That must clear all read requests together and offer the operands to the function unit in the very next cycle.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef struct packed {
        logic busy;
        logic done;
        logic die;
        logic disp_pend;
        logic alu_sent;
        logic wr_phase;
    } cu_state_t;

    // Whether source idx needs a register read for this operation
    function automatic logic src_needed(input int idx, input bit has_zero,
                                        input bit has_imm, input logic zsel,
                                        input logic isel);
        logic n;
        n = 1'b1;
        if (idx == 0 && has_zero && zsel) n = 1'b0;
        if (idx == 1 && has_imm && isel) n = 1'b0;
        return n;
    endfunction

    // Value a source holds at issue time (meaningful only when not read)
    function automatic logic [63:0] src_seed(input int idx, input bit has_imm,
                                             input logic isel,
                                             input logic [63:0] imm);
        logic [63:0] v;
        v = '0;
        if (idx == 1 && has_imm && isel) v = imm;
        return v;
    endfunction

endpackage

// File: rtl/cu_src_slot.sv
module cu_src_slot #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          need,
    input  logic [DW-1:0] seed,
    input  logic          clear,
    input  logic          grant,
    input  logic [DW-1:0] data,
    output logic          req,
    output logic [DW-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            val <= '0;
        end else if (load) begin
            req <= need;
            val <= seed;
        end else if (clear) begin
            req <= 1'b0;
        end else if (req && grant) begin
            req <= 1'b0;
            val <= data;
        end
    end
endmodule

// File: rtl/cu_dst_slot.sv
module cu_dst_slot #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] res,
    input  logic          clear,
    input  logic          fire,
    output logic          req,
    output logic [DW-1:0] val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            val <= '0;
        end else if (load) begin
            req <= 1'b1;
            val <= res;
        end else if (clear || fire) begin
            req <= 1'b0;
        end
    end
endmodule

// File: rtl/cu_seq.sv
module cu_seq
    import cu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic reads_clear,
    input  logic alu_ack,
    input  logic res_valid,
    input  logic wr_last,
    input  logic kill,
    output logic accept,
    output logic alu_req,
    output logic capture,
    output logic kill_now,
    output cu_state_t st
);
    assign accept   = issue && !st.done;
    assign kill_now = kill && st.busy && !st.die;
    assign alu_req  = st.busy && !st.die && st.disp_pend && reads_clear;
    assign capture  = st.alu_sent && res_valid && !st.die && !kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.done <= accept || st.busy;
            st.die  <= kill_now;

            if (accept)                      st.busy <= 1'b1;
            else if (st.die)                 st.busy <= 1'b0;
            else if (kill_now)               st.busy <= 1'b1;
            else if (st.wr_phase && wr_last) st.busy <= 1'b0;

            if (accept)                      st.disp_pend <= 1'b1;
            else if (kill_now || st.die)     st.disp_pend <= 1'b0;
            else if (alu_req && alu_ack)     st.disp_pend <= 1'b0;

            if (kill_now || st.die || capture) st.alu_sent <= 1'b0;
            else if (alu_req && alu_ack)       st.alu_sent <= 1'b1;

            if (kill_now || st.die || wr_last) st.wr_phase <= 1'b0;
            else if (capture)                  st.wr_phase <= 1'b1;
        end
    end
endmodule

// File: rtl/compunit_ctrl.sv
module compunit_ctrl
    import cu_pkg::*;
#(
    parameter int NSRC       = 3,
    parameter int NDST       = 2,
    parameter int DW         = 16,
    parameter bit HAS_ZERO_A = 1'b1,
    parameter bit HAS_IMM    = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic               zero_a_i,
    input  logic               imm_sel_i,
    input  logic [DW-1:0]      imm_i,
    output logic [NSRC-1:0]    rd_req_o,
    input  logic [NSRC-1:0]    rd_grant_i,
    input  logic [NSRC*DW-1:0] rd_data_i,
    output logic               alu_req_o,
    input  logic               alu_ack_i,
    output logic [NSRC*DW-1:0] alu_op_o,
    input  logic               alu_res_valid_i,
    input  logic [NDST*DW-1:0] alu_res_i,
    output logic [NDST-1:0]    wr_req_o,
    input  logic [NDST-1:0]    wr_grant_i,
    input  logic               shadow_n_i,
    input  logic               kill_i,
    output logic [NDST*DW-1:0] data_o,
    output logic               busy_o,
    output logic               done_o
);
    localparam int SW = NSRC * DW;
    localparam int RW = NDST * DW;

    cu_state_t        st;
    logic             accept, capture, kill_now, wr_last;
    logic [NDST-1:0]  wr_fire;
    logic [63:0]      imm_wide;

    assign imm_wide = 64'(imm_i);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [63:0] seed_w;
        assign seed_w = src_seed(i, HAS_IMM, imm_sel_i, imm_wide);
        cu_src_slot #(.DW(DW)) u_src (
            .clk   (clk),
            .rst   (rst),
            .load  (accept),
            .need  (src_needed(i, HAS_ZERO_A, HAS_IMM, zero_a_i, imm_sel_i)),
            .seed  (seed_w[DW-1:0]),
            .clear (kill_now),
            .grant (rd_grant_i[i]),
            .data  (rd_data_i[i*DW +: DW]),
            .req   (rd_req_o[i]),
            .val   (alu_op_o[i*DW +: DW])
        );
    end

    assign wr_fire = wr_req_o & wr_grant_i & {NDST{shadow_n_i && !st.die}};
    assign wr_last = st.wr_phase && ((wr_req_o & ~wr_fire) == '0);

    for (genvar j = 0; j < NDST; j++) begin : g_dst
        cu_dst_slot #(.DW(DW)) u_dst (
            .clk   (clk),
            .rst   (rst),
            .load  (capture),
            .res   (alu_res_i[j*DW +: DW]),
            .clear (kill_now),
            .fire  (wr_fire[j]),
            .req   (wr_req_o[j]),
            .val   (data_o[j*DW +: DW])
        );
    end

    cu_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue_i),
        .reads_clear (rd_req_o == '0),
        .alu_ack     (alu_ack_i),
        .res_valid   (alu_res_valid_i),
        .wr_last     (wr_last),
        .kill        (kill_i),
        .accept      (accept),
        .alu_req     (alu_req_o),
        .capture     (capture),
        .kill_now    (kill_now),
        .st          (st)
    );

    assign busy_o = st.busy;
    assign done_o = st.done;

    if (SW < 1 || RW < 1) begin : g_bad
        initial $error("compunit_ctrl: bad width parameters");
    end
endmodule

// File: rtl/compunit_ctrl_props.sv
module compunit_ctrl_props #(
    parameter int NSRC = 3,
    parameter int NDST = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_i,
    input logic [NSRC-1:0] rd_req_o,
    input logic            alu_req_o,
    input logic            alu_ack_i,
    input logic [NDST-1:0] wr_req_o,
    input logic [NDST-1:0] wr_grant_i,
    input logic            shadow_n_i,
    input logic            kill_i,
    input logic            busy_o,
    input logic            done_o
);
    p_issue_start_r1: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !done_o) |=> (busy_o && done_o));

    p_alu_gate_r3: assert property (@(posedge clk) disable iff (rst)
        alu_req_o |-> (busy_o && rd_req_o == '0));

    p_alu_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (alu_req_o && !alu_ack_i && !kill_i) |=> alu_req_o);

    p_reads_over_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o != '0) |-> (rd_req_o == '0));

    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!shadow_n_i && !kill_i && wr_req_o != '0) |=> (wr_req_o == $past(wr_req_o)));

    p_wr_release_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !kill_i && shadow_n_i && wr_req_o != '0 &&
         (wr_req_o & ~wr_grant_i) == '0) |=> (!busy_o && wr_req_o == '0));

    p_done_lag_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    p_done_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && done_o) |=> !done_o);

    p_kill_linger_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && kill_i && !$past(kill_i)) |=>
        (busy_o && rd_req_o == '0 && wr_req_o == '0));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (rd_req_o == '0 && wr_req_o == '0 && !alu_req_o));
endmodule

bind compunit_ctrl compunit_ctrl_props #(.NSRC(NSRC), .NDST(NDST)) u_props (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue_i),
    .rd_req_o   (rd_req_o),
    .alu_req_o  (alu_req_o),
    .alu_ack_i  (alu_ack_i),
    .wr_req_o   (wr_req_o),
    .wr_grant_i (wr_grant_i),
    .shadow_n_i (shadow_n_i),
    .kill_i     (kill_i),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/compunit_ctrl_test.sv
module compunit_ctrl_test;
    localparam int DW = 16;
    localparam int NS = 3;
    localparam int ND = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic issue_i = 0, zero_a_i = 0, imm_sel_i = 0;
    logic [DW-1:0] imm_i = '0;
    logic [NS-1:0] rd_req_o, rd_grant_i = '0;
    logic [NS*DW-1:0] rd_data_i = '0, alu_op_o;
    logic alu_req_o, alu_ack_i = 0, alu_res_valid_i = 0;
    logic [ND*DW-1:0] alu_res_i = '0, data_o;
    logic [ND-1:0] wr_req_o, wr_grant_i = '0;
    logic shadow_n_i = 1, kill_i = 0, busy_o, done_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    compunit_ctrl #(.NSRC(NS), .NDST(ND), .DW(DW)) uut (.*);

    // [67] all grants together, [66] shadow stall, [65] zero A, [64] imm B,
    // [63:48] A, [47:32] B, [31:16] C, [15:0] immediate
    localparam logic [67:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0F0F, 16'h0001, 16'hAAAA},
        {1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0002, 16'h8000, 16'h5555},
        {1'b0, 1'b1, 1'b1, 1'b0, 16'h7777, 16'h0100, 16'h0010, 16'h0000},
        {1'b0, 1'b0, 1'b0, 1'b1, 16'h0042, 16'hDEAD, 16'h0003, 16'hBEEF},
        {1'b1, 1'b1, 1'b1, 1'b1, 16'h9999, 16'h8888, 16'h4321, 16'h00FE},
        {1'b0, 1'b0, 1'b1, 1'b1, 16'hCAFE, 16'hF00D, 16'h1111, 16'h2222}
    };

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_issue(input logic za, input logic is, input logic [DW-1:0] imm);
        @(negedge clk);
        issue_i = 1; zero_a_i = za; imm_sel_i = is; imm_i = imm;
        @(negedge clk);
        issue_i = 0; zero_a_i = 0; imm_sel_i = 0;
    endtask

    task automatic alu_exchange(input logic [NS*DW-1:0] exp_ops, output logic [ND*DW-1:0] res);
        logic [DW-1:0] a, b, c;
        a = exp_ops[0 +: DW]; b = exp_ops[DW +: DW]; c = exp_ops[2*DW +: DW];
        check("R3 alu_req after reads", 64'(alu_req_o), 64'd1);
        check("R3 operands", 64'(alu_op_o), 64'(exp_ops));
        alu_ack_i = 1;
        @(negedge clk);
        alu_ack_i = 0;
        check("R3 alu_req drops after accept", 64'(alu_req_o), 64'd0);
        res = {a ^ b ^ c, a + b + c};
        alu_res_valid_i = 1; alu_res_i = res;
        @(negedge clk);
        alu_res_valid_i = 0;
        check("R6 write requests raised", 64'(wr_req_o), 64'd3);
        check("R6 reads over", 64'(rd_req_o), 64'd0);
    endtask

    task automatic run_op(input logic [67:0] v);
        logic za, is, all, shd;
        logic [DW-1:0] a, b, c, imm;
        logic [NS-1:0] mask;
        logic [NS*DW-1:0] ops;
        logic [ND*DW-1:0] res;
        {all, shd, za, is, a, b, c, imm} = v;
        mask = {1'b1, ~is, ~za};
        ops = {c, is ? imm : b, za ? 16'h0 : a};
        pulse_issue(za, is, imm);
        check("R1 busy after issue", 64'(busy_o), 64'd1);
        check("R1 done after issue", 64'(done_o), 64'd1);
        check("R1/R4/R5 read mask", 64'(rd_req_o), 64'(mask));
        rd_data_i = {c, b, a};
        if (all) begin
            rd_grant_i = mask;
            @(negedge clk);
            rd_grant_i = '0;
            check("R2 joint grant clears", 64'(rd_req_o), 64'd0);
        end else begin
            for (int i = 0; i < NS; i++) begin
                if (mask[i]) begin
                    rd_grant_i = NS'(1) << i;
                    @(negedge clk);
                    rd_grant_i = '0;
                    check("R2 request bit clears", 64'(rd_req_o[i]), 64'd0);
                end
            end
        end
        rd_data_i = '0;
        alu_exchange(ops, res);
        if (shd) begin
            shadow_n_i = 0; wr_grant_i = 2'b11;
            @(negedge clk);
            check("R7 shadow holds writes", 64'(wr_req_o), 64'd3);
            shadow_n_i = 1;
        end
        wr_grant_i = 2'b01;
        @(negedge clk);
        check("R8 partial write", 64'(wr_req_o), 64'd2);
        check("R8 busy during writes", 64'(busy_o), 64'd1);
        wr_grant_i = 2'b10;
        @(negedge clk);
        wr_grant_i = '0;
        check("R8 writes cleared", 64'(wr_req_o), 64'd0);
        check("R8 busy dropped", 64'(busy_o), 64'd0);
        check("R8 result", 64'(data_o), 64'(res));
        check("R9 done lingers", 64'(done_o), 64'd1);
        @(negedge clk);
        check("R9 done dropped", 64'(done_o), 64'd0);
        check("R12 idle quiet", 64'({rd_req_o, wr_req_o, alu_req_o}), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [ND*DW-1:0] res;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R12 reset busy", 64'(busy_o), 64'd0);
        check("R12 reset done", 64'(done_o), 64'd0);
        check("R12 reset requests", 64'({rd_req_o, wr_req_o, alu_req_o}), 64'd0);

        for (int k = 0; k < 6; k++) run_op(VEC[k]);

        // R11 / R2: repeated issue and stray grant
        pulse_issue(0, 0, '0);
        issue_i = 1; zero_a_i = 1; imm_sel_i = 1;
        @(negedge clk);
        issue_i = 0; zero_a_i = 0; imm_sel_i = 0;
        check("R11 issue while busy ignored", 64'(rd_req_o), 64'd7);
        rd_data_i = {16'h3, 16'h2, 16'h00A1};
        rd_grant_i = 3'b001;
        @(negedge clk);
        rd_data_i = {16'h3, 16'h2, 16'h00B2};
        @(negedge clk);
        check("R2 stray grant no effect", 64'(rd_req_o), 64'd6);
        rd_grant_i = 3'b110;
        @(negedge clk);
        rd_grant_i = '0;
        check("R2 value from granted cycle", 64'(alu_op_o[0 +: DW]), 64'h00A1);
        alu_exchange({16'h3, 16'h2, 16'h00A1}, res);
        wr_grant_i = 2'b11;
        @(negedge clk);
        wr_grant_i = '0;
        check("R8 dual grant release", 64'(busy_o), 64'd0);
        issue_i = 1;
        @(negedge clk);
        issue_i = 0;
        check("R11 issue while done ignored busy", 64'(busy_o), 64'd0);
        check("R11 issue while done ignored done", 64'(done_o), 64'd0);

        // R10: kill during read phase
        pulse_issue(0, 0, '0);
        kill_i = 1;
        @(negedge clk);
        kill_i = 0;
        check("R10 requests cleared", 64'(rd_req_o), 64'd0);
        check("R10 busy lingers", 64'(busy_o), 64'd1);
        @(negedge clk);
        check("R10 busy cleared", 64'(busy_o), 64'd0);
        check("R10 done lingers", 64'(done_o), 64'd1);
        @(negedge clk);
        check("R10 done cleared", 64'(done_o), 64'd0);

        // R10: kill in same cycle as final write grant
        pulse_issue(1, 1, 16'h0005);
        rd_data_i = {16'h0007, 16'h0, 16'h0};
        rd_grant_i = 3'b100;
        @(negedge clk);
        rd_grant_i = '0;
        alu_exchange({16'h0007, 16'h0005, 16'h0000}, res);
        wr_grant_i = 2'b11; kill_i = 1;
        @(negedge clk);
        wr_grant_i = '0; kill_i = 0;
        check("R10 kill wins writes cleared", 64'(wr_req_o), 64'd0);
        check("R10 kill wins busy lingers", 64'(busy_o), 64'd1);
        @(negedge clk);
        check("R10 kill wins busy cleared", 64'(busy_o), 64'd0);
        @(negedge clk);
        check("R12 quiet after kill", 64'({done_o, rd_req_o, wr_req_o, alu_req_o}), 64'd0);

        summary();
        $finish;
    end
endmodule